// File: doc/BRIEF.md
# In-Order Retirement Unit

This block retires instructions from the oldest end of an in-order queue that tracks entries of an out-of-order instruction window. Each cycle it walks the queue from the oldest entry towards the youngest, using up to `RET_W` retire slots, and stops at the first entry that cannot leave. Entries are named by their window slot index. They join the queue through a one-per-cycle append port. Status for every window slot arrives as flag vectors indexed by that slot: complete, faulted, speculative, squashed path, memory access, held in the store buffer, issued and flush.

Entries on a squashed path leave without touching architectural state. A faulted entry on the live path does not retire. Instead it raises a pending exception with its cause code, and no entry retires while that exception is pending. A memory entry still held in the store buffer asks the store buffer to release it in the same cycle. The response either lets the entry retire, stalls it for a retry on a later cycle, or turns into a coherency exception. Each cycle the unit reports why it stopped and how many slots went unused.

Top module: `retire_unit`

## Requirements
- R1: While `exc_pend_o` is 1, no entry retires (`ret_vld_o` = 0), `stall_code_o` is 7 and `stall_slots_o` equals `RET_W`.
- R2: Retirement takes entries only in queue order, starting at the oldest. An entry is eligible when it is complete, or when it is faulted and not speculative. The first ineligible entry ends the walk, and every entry younger than it stays in the queue.
- R3: When the walk reaches an eligible faulted entry that is not on a squashed path, that entry does not retire and `stall_code_o` is 7. On the next clock `exc_pend_o` becomes 1 and `exc_cause_o` holds that entry's code from `cause_i`. The code then stays unchanged while the exception is pending.
- R4: A live-path memory entry (`ldst_i`=1) that is held in the store buffer (`insb_i`=1) drives `sb_req_o`=1 with its index on `sb_idx_o`. The response on `sb_resp_i` decides the outcome. Value 0 lets the entry retire. Value 1 (or 3) stops the walk with stall code 3, and the entry is tried again on a later cycle. Only one request is made per cycle, so a second such entry in the same cycle stops the walk with stall code 3.
- R5: Response value 2 (line evicted) stops the walk with stall code 7, and on the next clock it sets a pending exception with cause all ones (31 at default width).
- R6: An eligible entry on a squashed path (`squash_i`=1) leaves the queue and uses a retire slot. Its `ret_arch_o` bit is 0, and it neither raises an exception nor makes a store-buffer request, even if it is faulted.
- R7: When the walk stops, `stall_code_o` gives the reason. The queue ran out with `icache_stall_i`=1: 1. The queue ran out right after a live-path entry flagged `flush_i`: 2. A store-buffer stall: 3. The blocking entry is not issued: 4, or 2 if it is flagged flush. The blocking entry is issued and is a memory access: 5. Anything else: 6.
- R8: Retire strobes are contiguous from slot 0 (the oldest) upward. `stall_slots_o` is `RET_W` minus the number retired. `stall_code_o` is 0 exactly when all `RET_W` slots retire.
- R9: Entries retire in the order they were appended. `ret_idx_o` slot k (bits k*IW upward) carries the index retiring in slot k. An entry appended in a cycle can retire no earlier than the next cycle, including when the queue drains in that same cycle.
- R10: A pulse on `exc_clr_i` while an exception is pending clears `exc_pend_o` on the next clock, and retirement resumes from the same head entry.
- R11: After reset the queue is empty, no exception is pending, nothing retires, and `stall_slots_o` equals `RET_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enq_vld_i | input | 1 | Append an entry at the young end |
| enq_idx_i | input | IW | Window index to append |
| done_i | input | DEPTH | Per-slot complete flag |
| fault_i | input | DEPTH | Per-slot fault flag |
| spec_i | input | DEPTH | Per-slot speculative flag |
| squash_i | input | DEPTH | Per-slot squashed-path flag |
| ldst_i | input | DEPTH | Per-slot memory-access flag |
| insb_i | input | DEPTH | Per-slot held-in-store-buffer flag |
| issued_i | input | DEPTH | Per-slot issued flag |
| flush_i | input | DEPTH | Per-slot flush flag |
| cause_i | input | DEPTH*CAUSE_W | Per-slot exception code |
| icache_stall_i | input | 1 | Fetch is stalled on the instruction cache |
| sb_resp_i | input | 2 | Store-buffer response: 0 done, 1 wait, 2 evicted |
| exc_clr_i | input | 1 | Pending exception has been handled |
| sb_req_o | output | 1 | Store-buffer release request |
| sb_idx_o | output | IW | Index being released |
| ret_vld_o | output | RET_W | Retire strobe per slot |
| ret_arch_o | output | RET_W | Slot retires with architectural effect |
| ret_idx_o | output | RET_W*IW | Index retiring in each slot |
| exc_pend_o | output | 1 | Exception pending |
| exc_cause_o | output | CAUSE_W | Pending exception cause |
| stall_code_o | output | 3 | Reason the walk stopped |
| stall_slots_o | output | SW | Unused retire slots this cycle |

## Verification
The assertions assume that an index is appended only when it is not already queued and the queue is not full, and that the store-buffer response is settled in the same cycle as the request. The bench appends distinct window indices one at a time into a queue that never fills. It changes flag vectors and the store-buffer response only just after the falling edge, while no exception is being raised, so every walk sees stable inputs. The clear pulse is driven only while an exception is pending.

// File: rtl/retire_pkg.sv
package retire_pkg;

    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_ICACHE  = 3'd1,
        ST_FLUSH   = 3'd2,
        ST_LDST    = 3'd3,
        ST_NOISSUE = 3'd4,
        ST_MEMPH   = 3'd5,
        ST_OTHER   = 3'd6,
        ST_EXCEPT  = 3'd7
    } stall_e;

    typedef enum logic [1:0] {
        SB_DONE  = 2'd0,
        SB_WAIT  = 2'd1,
        SB_EVICT = 2'd2,
        SB_RSVD  = 2'd3
    } sb_resp_e;

    typedef enum logic [2:0] {
        STOP_NONE  = 3'd0,
        STOP_EMPTY = 3'd1,
        STOP_EXC   = 3'd2,
        STOP_SB    = 3'd3,
        STOP_ENTRY = 3'd4
    } stop_e;

endpackage

// File: rtl/rq_link_list.sv
// Oldest-to-youngest doubly linked order over window slots.
module rq_link_list #(
    parameter int DEPTH = 32,
    parameter int RET_W = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int SW   = $clog2(RET_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enq_vld_i,
    input  logic [IW-1:0]         enq_idx_i,
    input  logic [SW-1:0]         deq_n_i,
    output logic [RET_W*IW-1:0]   slot_idx_o,
    output logic [RET_W-1:0]      slot_ok_o,
    output logic [CNTW-1:0]       count_o
);

    localparam logic [IW:0] PTR_NONE = {1'b1, {IW{1'b0}}};

    typedef struct packed {
        logic [IW-1:0]             head;
        logic [IW-1:0]             tail;
        logic [CNTW-1:0]           cnt;
        logic [DEPTH-1:0][IW:0]    nxt;
        logic [DEPTH-1:0][IW:0]    prv;
    } list_t;

    list_t q, d;
    logic [RET_W:0][IW-1:0] pos;
    logic [CNTW-1:0]        remain;

    // walk the forward links from the head
    always_comb begin
        pos[0] = q.head;
        for (int k = 0; k < RET_W; k++) begin
            pos[k+1] = q.nxt[pos[k]][IW-1:0];
        end
    end

    for (genvar k = 0; k < RET_W; k++) begin : g_slot
        assign slot_idx_o[k*IW +: IW] = pos[k];
        assign slot_ok_o[k]           = (CNTW'(k) < q.cnt);
    end

    assign count_o = q.cnt;

    always_comb begin
        d      = q;
        remain = q.cnt - CNTW'(deq_n_i);
        if (deq_n_i != '0 && remain != '0) begin
            d.head             = pos[deq_n_i];
            d.prv[pos[deq_n_i]] = PTR_NONE;
        end
        if (enq_vld_i) begin
            d.nxt[enq_idx_i] = PTR_NONE;
            d.tail           = enq_idx_i;
            if (remain == '0) begin
                d.head           = enq_idx_i;
                d.prv[enq_idx_i] = PTR_NONE;
            end else begin
                d.nxt[q.tail]    = {1'b0, enq_idx_i};
                d.prv[enq_idx_i] = {1'b0, q.tail};
            end
        end
        d.cnt = remain + CNTW'(enq_vld_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/rq_select.sv
// Per-cycle walk over the oldest RET_W queue positions.
module rq_select
    import retire_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int RET_W   = 4,
    parameter int CAUSE_W = 5,
    localparam int IW     = $clog2(DEPTH),
    localparam int SW     = $clog2(RET_W + 1)
) (
    input  logic                      pend_i,
    input  logic [RET_W*IW-1:0]       slot_idx_i,
    input  logic [RET_W-1:0]          slot_ok_i,
    input  logic [DEPTH-1:0]          done_i,
    input  logic [DEPTH-1:0]          fault_i,
    input  logic [DEPTH-1:0]          spec_i,
    input  logic [DEPTH-1:0]          squash_i,
    input  logic [DEPTH-1:0]          ldst_i,
    input  logic [DEPTH-1:0]          insb_i,
    input  logic [DEPTH-1:0]          flush_i,
    input  logic [DEPTH*CAUSE_W-1:0]  cause_i,
    input  logic [1:0]                sb_resp_i,
    output logic                      sb_req_o,
    output logic [IW-1:0]             sb_idx_o,
    output logic [RET_W-1:0]          ret_vld_o,
    output logic [RET_W-1:0]          ret_arch_o,
    output logic [SW-1:0]             n_ret_o,
    output logic                      raise_o,
    output logic [CAUSE_W-1:0]        raise_cause_o,
    output stop_e                     stop_o,
    output logic [IW-1:0]             stop_idx_o,
    output logic                      last_flush_o
);

    localparam logic [CAUSE_W-1:0] COH_CAUSE = {CAUSE_W{1'b1}};

    always_comb begin
        logic          go;
        logic          sb_used;
        logic [IW-1:0] idx;
        sb_req_o      = 1'b0;
        sb_idx_o      = '0;
        ret_vld_o     = '0;
        ret_arch_o    = '0;
        n_ret_o       = '0;
        raise_o       = 1'b0;
        raise_cause_o = '0;
        stop_o        = STOP_NONE;
        stop_idx_o    = '0;
        last_flush_o  = 1'b0;
        go            = 1'b1;
        sb_used       = 1'b0;
        for (int k = 0; k < RET_W; k++) begin
            idx = slot_idx_i[k*IW +: IW];
            if (go) begin
                if (pend_i) begin
                    stop_o = STOP_EXC;
                    go     = 1'b0;
                end else if (!slot_ok_i[k]) begin
                    stop_o = STOP_EMPTY;
                    go     = 1'b0;
                end else if (!(done_i[idx] || (fault_i[idx] && !spec_i[idx]))) begin
                    stop_o     = STOP_ENTRY;
                    stop_idx_o = idx;
                    go         = 1'b0;
                end else if (squash_i[idx]) begin
                    ret_vld_o[k] = 1'b1;
                    n_ret_o      = n_ret_o + SW'(1);
                    last_flush_o = 1'b0;
                end else if (fault_i[idx]) begin
                    raise_o       = 1'b1;
                    raise_cause_o = cause_i[idx*CAUSE_W +: CAUSE_W];
                    stop_o        = STOP_EXC;
                    go            = 1'b0;
                end else if (ldst_i[idx] && insb_i[idx]) begin
                    if (sb_used) begin
                        stop_o = STOP_SB;
                        go     = 1'b0;
                    end else begin
                        sb_used  = 1'b1;
                        sb_req_o = 1'b1;
                        sb_idx_o = idx;
                        case (sb_resp_e'(sb_resp_i))
                            SB_DONE: begin
                                ret_vld_o[k]  = 1'b1;
                                ret_arch_o[k] = 1'b1;
                                n_ret_o       = n_ret_o + SW'(1);
                                last_flush_o  = flush_i[idx];
                            end
                            SB_EVICT: begin
                                raise_o       = 1'b1;
                                raise_cause_o = COH_CAUSE;
                                stop_o        = STOP_EXC;
                                go            = 1'b0;
                            end
                            default: begin
                                stop_o = STOP_SB;
                                go     = 1'b0;
                            end
                        endcase
                    end
                end else begin
                    ret_vld_o[k]  = 1'b1;
                    ret_arch_o[k] = 1'b1;
                    n_ret_o       = n_ret_o + SW'(1);
                    last_flush_o  = flush_i[idx];
                end
            end
        end
    end

endmodule

// File: rtl/rq_stall_class.sv
// Maps the walk's stopping point onto a stall reason.
module rq_stall_class
    import retire_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int RET_W  = 4,
    localparam int IW    = $clog2(DEPTH),
    localparam int SW    = $clog2(RET_W + 1)
) (
    input  stop_e            stop_i,
    input  logic [IW-1:0]    stop_idx_i,
    input  logic [SW-1:0]    n_ret_i,
    input  logic [DEPTH-1:0] issued_i,
    input  logic [DEPTH-1:0] flush_i,
    input  logic [DEPTH-1:0] ldst_i,
    input  logic             icache_i,
    input  logic             last_flush_i,
    output stall_e           code_o,
    output logic [SW-1:0]    slots_o
);

    always_comb begin
        case (stop_i)
            STOP_NONE:  code_o = ST_NONE;
            STOP_EXC:   code_o = ST_EXCEPT;
            STOP_SB:    code_o = ST_LDST;
            STOP_EMPTY: code_o = icache_i     ? ST_ICACHE :
                                 last_flush_i ? ST_FLUSH  : ST_OTHER;
            default: begin
                if (!issued_i[stop_idx_i])
                    code_o = flush_i[stop_idx_i] ? ST_FLUSH : ST_NOISSUE;
                else
                    code_o = ldst_i[stop_idx_i] ? ST_MEMPH : ST_OTHER;
            end
        endcase
        slots_o = SW'(RET_W) - n_ret_i;
    end

endmodule

// File: rtl/retire_unit.sv
module retire_unit
    import retire_pkg::*;
#(
    parameter int RET_W   = 4,
    parameter int DEPTH   = 32,
    parameter int CAUSE_W = 5,
    localparam int IW     = $clog2(DEPTH),
    localparam int SW     = $clog2(RET_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enq_vld_i,
    input  logic [IW-1:0]             enq_idx_i,
    input  logic [DEPTH-1:0]          done_i,
    input  logic [DEPTH-1:0]          fault_i,
    input  logic [DEPTH-1:0]          spec_i,
    input  logic [DEPTH-1:0]          squash_i,
    input  logic [DEPTH-1:0]          ldst_i,
    input  logic [DEPTH-1:0]          insb_i,
    input  logic [DEPTH-1:0]          issued_i,
    input  logic [DEPTH-1:0]          flush_i,
    input  logic [DEPTH*CAUSE_W-1:0]  cause_i,
    input  logic                      icache_stall_i,
    input  logic [1:0]                sb_resp_i,
    input  logic                      exc_clr_i,
    output logic                      sb_req_o,
    output logic [IW-1:0]             sb_idx_o,
    output logic [RET_W-1:0]          ret_vld_o,
    output logic [RET_W-1:0]          ret_arch_o,
    output logic [RET_W*IW-1:0]       ret_idx_o,
    output logic                      exc_pend_o,
    output logic [CAUSE_W-1:0]        exc_cause_o,
    output logic [2:0]                stall_code_o,
    output logic [SW-1:0]             stall_slots_o
);

    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic               pend;
        logic [CAUSE_W-1:0] cause;
    } exc_t;

    exc_t q, d;

    logic [RET_W*IW-1:0] slot_idx;
    logic [RET_W-1:0]    slot_ok;
    logic [CNTW-1:0]     count_q;
    logic [SW-1:0]       n_ret;
    logic                raise;
    logic [CAUSE_W-1:0]  raise_cause;
    stop_e               stop;
    logic [IW-1:0]       stop_idx;
    logic                last_flush;
    stall_e              code;

    rq_link_list #(.DEPTH(DEPTH), .RET_W(RET_W)) i_list (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_vld_i  (enq_vld_i),
        .enq_idx_i  (enq_idx_i),
        .deq_n_i    (n_ret),
        .slot_idx_o (slot_idx),
        .slot_ok_o  (slot_ok),
        .count_o    (count_q)
    );

    rq_select #(.DEPTH(DEPTH), .RET_W(RET_W), .CAUSE_W(CAUSE_W)) i_sel (
        .pend_i        (q.pend),
        .slot_idx_i    (slot_idx),
        .slot_ok_i     (slot_ok),
        .done_i        (done_i),
        .fault_i       (fault_i),
        .spec_i        (spec_i),
        .squash_i      (squash_i),
        .ldst_i        (ldst_i),
        .insb_i        (insb_i),
        .flush_i       (flush_i),
        .cause_i       (cause_i),
        .sb_resp_i     (sb_resp_i),
        .sb_req_o      (sb_req_o),
        .sb_idx_o      (sb_idx_o),
        .ret_vld_o     (ret_vld_o),
        .ret_arch_o    (ret_arch_o),
        .n_ret_o       (n_ret),
        .raise_o       (raise),
        .raise_cause_o (raise_cause),
        .stop_o        (stop),
        .stop_idx_o    (stop_idx),
        .last_flush_o  (last_flush)
    );

    rq_stall_class #(.DEPTH(DEPTH), .RET_W(RET_W)) i_cls (
        .stop_i       (stop),
        .stop_idx_i   (stop_idx),
        .n_ret_i      (n_ret),
        .issued_i     (issued_i),
        .flush_i      (flush_i),
        .ldst_i       (ldst_i),
        .icache_i     (icache_stall_i),
        .last_flush_i (last_flush),
        .code_o       (code),
        .slots_o      (stall_slots_o)
    );

    always_comb begin
        d = q;
        if (raise) begin
            d.pend  = 1'b1;
            d.cause = raise_cause;
        end else if (exc_clr_i) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ret_idx_o    = slot_idx;
    assign exc_pend_o   = q.pend;
    assign exc_cause_o  = q.cause;
    assign stall_code_o = code;

endmodule

// File: rtl/retire_unit_chk.sv
module retire_unit_chk #(
    parameter int RET_W   = 4,
    parameter int DEPTH   = 32,
    parameter int CAUSE_W = 5,
    localparam int SW     = $clog2(RET_W + 1),
    localparam int CNTW   = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RET_W-1:0]   ret_vld_o,
    input logic [2:0]         stall_code_o,
    input logic [SW-1:0]      stall_slots_o,
    input logic               exc_pend_o,
    input logic [CAUSE_W-1:0] exc_cause_o,
    input logic               exc_clr_i,
    input logic               sb_req_o,
    input logic [CNTW-1:0]    count_q
);

    a_r1_hold_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend_o |-> (ret_vld_o == '0 && stall_code_o == 3'd7));

    a_r3_raise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_pend_o && stall_code_o == 3'd7) |=> exc_pend_o);

    a_r3_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_pend_o && $past(exc_pend_o)) |-> $stable(exc_cause_o));

    a_r4_sb_req_only_live: assert property (@(posedge clk) disable iff (!rst_n)
        sb_req_o |-> !exc_pend_o);

    a_r8_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_vld_o & (ret_vld_o + 1'b1)) == '0);

    a_r8_slot_sum: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ret_vld_o) + int'(stall_slots_o)) == RET_W);

    a_r8_none_means_full: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_code_o == 3'd0) |-> (ret_vld_o == {RET_W{1'b1}}));

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_pend_o && exc_clr_i) |=> !exc_pend_o);

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= DEPTH);

endmodule

bind retire_unit retire_unit_chk #(.RET_W(RET_W), .DEPTH(DEPTH), .CAUSE_W(CAUSE_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ret_vld_o     (ret_vld_o),
    .stall_code_o  (stall_code_o),
    .stall_slots_o (stall_slots_o),
    .exc_pend_o    (exc_pend_o),
    .exc_cause_o   (exc_cause_o),
    .exc_clr_i     (exc_clr_i),
    .sb_req_o      (sb_req_o),
    .count_q       (count_q)
);

// File: tb/test_retire_unit.sv
`timescale 1ns/1ps
module test_retire_unit;

    localparam int W  = 4;
    localparam int D  = 32;
    localparam int CW = 5;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enq_vld_i = 1'b0;
    logic [IW-1:0]   enq_idx_i = '0;
    logic [D-1:0]    done_i = '0, fault_i = '0, spec_i = '0, squash_i = '0;
    logic [D-1:0]    ldst_i = '0, insb_i = '0, issued_i = '0, flush_i = '0;
    logic [D*CW-1:0] cause_i = '0;
    logic            icache_stall_i = 1'b0;
    logic [1:0]      sb_resp_i = 2'd0;
    logic            exc_clr_i = 1'b0;
    logic            sb_req_o;
    logic [IW-1:0]   sb_idx_o;
    logic [W-1:0]    ret_vld_o, ret_arch_o;
    logic [W*IW-1:0] ret_idx_o;
    logic            exc_pend_o;
    logic [CW-1:0]   exc_cause_o;
    logic [2:0]      stall_code_o;
    logic [2:0]      stall_slots_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    retire_unit i_retire_unit (
        .clk(clk), .rst_n(rst_n), .enq_vld_i(enq_vld_i), .enq_idx_i(enq_idx_i),
        .done_i(done_i), .fault_i(fault_i), .spec_i(spec_i), .squash_i(squash_i),
        .ldst_i(ldst_i), .insb_i(insb_i), .issued_i(issued_i), .flush_i(flush_i),
        .cause_i(cause_i), .icache_stall_i(icache_stall_i), .sb_resp_i(sb_resp_i),
        .exc_clr_i(exc_clr_i), .sb_req_o(sb_req_o), .sb_idx_o(sb_idx_o),
        .ret_vld_o(ret_vld_o), .ret_arch_o(ret_arch_o), .ret_idx_o(ret_idx_o),
        .exc_pend_o(exc_pend_o), .exc_cause_o(exc_cause_o),
        .stall_code_o(stall_code_o), .stall_slots_o(stall_slots_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ridx(input int k);
        return int'(ret_idx_o[k*IW +: IW]);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enq(input int idx);
        enq_vld_i = 1'b1;
        enq_idx_i = IW'(idx);
        tick();
        enq_vld_i = 1'b0;
    endtask

    task automatic clear_flags();
        done_i = '0; fault_i = '0; spec_i = '0; squash_i = '0;
        ldst_i = '0; insb_i = '0; issued_i = '0; flush_i = '0;
        cause_i = '0; sb_resp_i = 2'd0; icache_stall_i = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R11 pend", int'(exc_pend_o), 0);
        check("R11 ret", int'(ret_vld_o), 0);
        check("R11 slots", int'(stall_slots_o), W);
        check("R11 code empty", int'(stall_code_o), 6);
    endtask

    task automatic t_basic();
        clear_flags();
        enq(3); enq(7); enq(1); enq(9); enq(12); enq(20);
        #1;
        check("R7 not issued", int'(stall_code_o), 4);
        check("R2 blocked head", int'(ret_vld_o), 0);
        issued_i[3] = 1'b1; #1;
        check("R7 other", int'(stall_code_o), 6);
        ldst_i[3] = 1'b1; #1;
        check("R7 mem phase", int'(stall_code_o), 5);
        ldst_i[3] = 1'b0;
        done_i[3] = 1'b1; done_i[7] = 1'b1; done_i[1] = 1'b1;
        done_i[9] = 1'b1; done_i[12] = 1'b1; done_i[20] = 1'b1;
        #1;
        check("R8 full width", int'(ret_vld_o), 15);
        check("R8 code none", int'(stall_code_o), 0);
        check("R8 slots zero", int'(stall_slots_o), 0);
        check("R9 slot0", ridx(0), 3);
        check("R9 slot1", ridx(1), 7);
        check("R9 slot2", ridx(2), 1);
        check("R9 slot3", ridx(3), 9);
        tick(); #1;
        check("R8 partial", int'(ret_vld_o), 3);
        check("R9 slot0 next", ridx(0), 12);
        check("R9 slot1 next", ridx(1), 20);
        check("R8 slots two", int'(stall_slots_o), 2);
        tick();
    endtask

    task automatic t_squash();
        clear_flags();
        enq(2); enq(4); enq(6);
        done_i[2] = 1'b1; done_i[6] = 1'b1;
        done_i[4] = 1'b1; squash_i[4] = 1'b1; fault_i[4] = 1'b1;
        #1;
        check("R6 drained", int'(ret_vld_o), 7);
        check("R6 arch bits", int'(ret_arch_o & 4'h7), 5);
        check("R6 no sb req", int'(sb_req_o), 0);
        tick(); #1;
        check("R6 no exception", int'(exc_pend_o), 0);
    endtask

    task automatic t_fault();
        clear_flags();
        enq(10); enq(11); enq(12);
        done_i[10] = 1'b1; done_i[12] = 1'b1;
        fault_i[11] = 1'b1; spec_i[11] = 1'b1; issued_i[11] = 1'b1;
        cause_i[11*CW +: CW] = 5'd5;
        #1;
        check("R2 spec fault waits", int'(ret_vld_o), 1);
        check("R2 stop code", int'(stall_code_o), 6);
        check("R2 slots", int'(stall_slots_o), 3);
        tick(); #1;
        check("R2 still blocked", int'(ret_vld_o), 0);
        check("R2 no pend", int'(exc_pend_o), 0);
        spec_i[11] = 1'b0; #1;
        check("R3 fault not retired", int'(ret_vld_o), 0);
        check("R3 code except", int'(stall_code_o), 7);
        tick(); #1;
        check("R3 pending", int'(exc_pend_o), 1);
        check("R3 cause", int'(exc_cause_o), 5);
        fault_i[11] = 1'b0; done_i[11] = 1'b1; #1;
        check("R1 no retire", int'(ret_vld_o), 0);
        check("R1 slots", int'(stall_slots_o), W);
        exc_clr_i = 1'b1;
        tick();
        exc_clr_i = 1'b0; #1;
        check("R10 cleared", int'(exc_pend_o), 0);
        check("R10 resume", int'(ret_vld_o), 3);
        check("R10 head", ridx(0), 11);
        tick();
    endtask

    task automatic t_sb();
        clear_flags();
        enq(14); enq(15); enq(16);
        ldst_i[14] = 1'b1; insb_i[14] = 1'b1; done_i[14] = 1'b1;
        ldst_i[15] = 1'b1; insb_i[15] = 1'b1; done_i[15] = 1'b1;
        done_i[16] = 1'b1;
        sb_resp_i = 2'd1; #1;
        check("R4 req", int'(sb_req_o), 1);
        check("R4 req idx", int'(sb_idx_o), 14);
        check("R4 wait stall", int'(stall_code_o), 3);
        check("R4 wait no retire", int'(ret_vld_o), 0);
        tick();
        sb_resp_i = 2'd0; #1;
        check("R4 retry idx", int'(sb_idx_o), 14);
        check("R4 one per cycle", int'(ret_vld_o), 1);
        check("R4 second stalls", int'(stall_code_o), 3);
        tick(); #1;
        check("R4 second idx", int'(sb_idx_o), 15);
        check("R4 drain", int'(ret_vld_o), 3);
        tick();
        enq(17);
        ldst_i[17] = 1'b1; insb_i[17] = 1'b1; done_i[17] = 1'b1;
        sb_resp_i = 2'd2; #1;
        check("R5 no retire", int'(ret_vld_o), 0);
        check("R5 code", int'(stall_code_o), 7);
        tick(); #1;
        check("R5 pending", int'(exc_pend_o), 1);
        check("R5 coherency cause", int'(exc_cause_o), 31);
        insb_i[17] = 1'b0; sb_resp_i = 2'd0;
        exc_clr_i = 1'b1;
        tick();
        exc_clr_i = 1'b0; #1;
        check("R10 retire after clear", ridx(0) * 16 + int'(ret_vld_o), 17 * 16 + 1);
        tick();
    endtask

    task automatic t_flush();
        clear_flags();
        enq(21);
        done_i[21] = 1'b1; flush_i[21] = 1'b1; #1;
        check("R7 flush empty", int'(stall_code_o), 2);
        tick(); #1;
        check("R7 plain empty", int'(stall_code_o), 6);
        icache_stall_i = 1'b1; #1;
        check("R7 icache empty", int'(stall_code_o), 1);
        icache_stall_i = 1'b0;
        flush_i[22] = 1'b1;
        enq(22); #1;
        check("R7 flush not issued", int'(stall_code_o), 2);
        done_i[22] = 1'b1;
        tick();
    endtask

    task automatic t_overlap();
        clear_flags();
        enq(25);
        done_i[25] = 1'b1; done_i[26] = 1'b1;
        enq_vld_i = 1'b1; enq_idx_i = 5'd26; #1;
        check("R9 old only", int'(ret_vld_o), 1);
        check("R9 old idx", ridx(0), 25);
        tick();
        enq_vld_i = 1'b0; #1;
        check("R9 appended retires", int'(ret_vld_o), 1);
        check("R9 appended idx", ridx(0), 26);
        tick();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_squash();
        t_fault();
        t_sb();
        t_flush();
        t_overlap();
        finish_run();
    end

endmodule